// File: doc/BRIEF.md
# Multi-Category Wavefront Issue Arbiter

This block decides, once per clock, which waiting wavefront instructions go to the execution categories. Wavefronts sit in slots arranged in SIMD groups. Only one group is examined per cycle, and the groups take turns in a fixed rotation. Every wave slot presents a ready flag, a mask of the categories its pending instruction may use, an age and a priority level. The arbiter then picks at most one wave for each category and never gives one wave more than one grant in the same cycle.

There are seven categories. Six are external: vector ALU, scalar ALU or scalar memory read, vector memory, branch or message, local shared memory, and export or global shared memory. A seventh, internal category holds buffer-local operations such as no-op, sleep, wait-count, barrier and set-priority. At most five external grants are made in one cycle. Internal grants do not count toward that limit. Categories are resolved in a fixed ascending order. Within a category the strongest candidate wins on priority, then on age, then on slot position. The result is registered, and each category carries its own valid bit, a global wave identifier and the group that was served.

Top module: `wia_issue_arb`

## Requirements
- R1: After reset, the group examined in the n-th cycle is n modulo NUM_GROUPS. The group index appears on `grant_group` together with the grants of that cycle.
- R2: Only waves of the examined group are candidates. Global wave w belongs to group w / WAVES_PER_GROUP, and a ready wave in any other group receives no grant.
- R3: A wave is a candidate for category c only when its ready bit is 1 and bit c of its category mask is 1. Bit 0 is vector ALU, 1 is scalar ALU/scalar memory, 2 is vector memory, 3 is branch/message, 4 is local shared memory, 5 is export/global shared memory and 6 is internal.
- R4: Within a category the candidate with the higher priority value wins. On equal priority the larger age value (the older wave) wins. On a full tie the lower slot index wins.
- R5: Categories are resolved from index 0 upward. A wave granted in a lower category is removed from all higher categories in that cycle, so no wave holds two grants.
- R6: Categories 0 to 5 together grant at most five instructions per cycle. Once five of them have granted, the remaining external category gets nothing. Category 6 is not counted and still grants.
- R7: Grants are registered. Inputs sampled at one rising edge show up on the outputs right after that edge. A category with no candidate drives its valid bit to 0 and its wave field to 0.
- R8: While `rst` is high, all valid bits are 0, `grant_group` is 0 and every wave field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wave_ready | input | NUM_GROUPS*WAVES_PER_GROUP | Ready flag per global wave |
| wave_cat_mask | input | NUM_GROUPS*WAVES_PER_GROUP*7 | Seven-bit category mask per wave, wave w at bits [w*7 +: 7] |
| wave_age | input | NUM_GROUPS*WAVES_PER_GROUP*AGE_W | Age per wave, larger is older |
| wave_prio | input | NUM_GROUPS*WAVES_PER_GROUP*PRIO_W | Priority level per wave, larger wins |
| grant_valid | output | 7 | Per-category grant valid |
| grant_wave | output | 7*WID_W | Global wave id per category, category c at [c*WID_W +: WID_W] |
| grant_group | output | GRP_W | Group served by the current grants |

## Verification
Random cycles use small age and priority ranges, so ties are frequent. They also use sparse masks in which one wave is often eligible for several categories. Every grant is compared with a bench model of the whole ordering, which separates a wrong priority compare from a wrong age or index tie-break. Directed cycles cover the remaining cases one at a time. One gives six distinct waves one external category each, which exercises the five-grant cap while the internal category must still grant. One offers a single high-priority wave to every category, which tests masking across the category order. Others place ready waves only in other groups, or offer masks without ready, and in both cases a correct design grants nothing.

// File: rtl/wia_pkg.sv
package wia_pkg;

    localparam int NUM_CAT       = 7;
    localparam int NUM_EXT       = 6;
    localparam int MAX_EXT_ISSUE = 5;
    localparam int CNT_W         = $clog2(NUM_CAT + 1);

    typedef enum logic [2:0] {
        CAT_VALU     = 3'd0,
        CAT_SALU     = 3'd1,
        CAT_VMEM     = 3'd2,
        CAT_BRMSG    = 3'd3,
        CAT_LDS      = 3'd4,
        CAT_EXPGDS   = 3'd5,
        CAT_INTERNAL = 3'd6
    } cat_e;

    // True when candidate a strictly outranks candidate b.
    function automatic logic outranks(input int unsigned prio_a, input int unsigned age_a,
                                      input int unsigned prio_b, input int unsigned age_b);
        return (prio_a > prio_b) || ((prio_a == prio_b) && (age_a > age_b));
    endfunction

    function automatic logic is_external(input int c);
        return c < NUM_EXT;
    endfunction

    function automatic int unsigned next_group(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/wia_group_ctr.sv
module wia_group_ctr #(
    parameter int NUM_GROUPS = 4,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [GRP_W-1:0] grp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grp <= '0;
        end else begin
            grp <= GRP_W'(wia_pkg::next_group(int'(grp), NUM_GROUPS));
        end
    end

    AST_GROUP_ROTATE: assert property (@(posedge clk) disable iff (rst)
        1 |=> (grp == (($past(grp) == GRP_W'(NUM_GROUPS - 1)) ? '0 : $past(grp) + 1'b1))) // R1
        else $error("group pointer skipped");

    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(grp) < NUM_GROUPS) // R1
        else $error("group pointer out of range");
endmodule

// File: rtl/wia_slot_view.sv
module wia_slot_view #(
    parameter int NUM_GROUPS = 4,
    parameter int SLOTS      = 10,
    parameter int AGE_W      = 8,
    parameter int PRIO_W     = 2,
    localparam int NW    = NUM_GROUPS * SLOTS,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [GRP_W-1:0]                   grp,
    input  logic [NW-1:0]                      wave_ready,
    input  logic [NW*wia_pkg::NUM_CAT-1:0]     wave_cat_mask,
    input  logic [NW*AGE_W-1:0]                wave_age,
    input  logic [NW*PRIO_W-1:0]               wave_prio,
    output logic [SLOTS-1:0]                   elig [wia_pkg::NUM_CAT],
    output logic [AGE_W-1:0]                   slot_age [SLOTS],
    output logic [PRIO_W-1:0]                  slot_prio [SLOTS]
);
    import wia_pkg::*;

    always_comb begin
        for (int c = 0; c < NUM_CAT; c++) elig[c] = '0;
        for (int s = 0; s < SLOTS; s++) begin
            int w;
            w = int'(grp) * SLOTS + s;
            slot_age[s]  = '0;
            slot_prio[s] = '0;
            if (w < NW) begin
                slot_age[s]  = wave_age[w*AGE_W +: AGE_W];
                slot_prio[s] = wave_prio[w*PRIO_W +: PRIO_W];
                for (int c = 0; c < NUM_CAT; c++) begin
                    elig[c][s] = wave_ready[w] & wave_cat_mask[w*NUM_CAT + c];
                end
            end
        end
    end
endmodule

// File: rtl/wia_cat_pick.sv
module wia_cat_pick #(
    parameter int SLOTS  = 10,
    parameter int AGE_W  = 8,
    parameter int PRIO_W = 2,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]  cand,
    input  logic [AGE_W-1:0]  age [SLOTS],
    input  logic [PRIO_W-1:0] prio [SLOTS],
    output logic              found,
    output logic [SLOT_W-1:0] win
);
    logic [AGE_W-1:0]  best_age;
    logic [PRIO_W-1:0] best_prio;

    // Scan low to high; a later slot replaces the best only if strictly stronger.
    always_comb begin
        found     = 1'b0;
        win       = '0;
        best_age  = '0;
        best_prio = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (cand[s] && (!found || wia_pkg::outranks(int'(prio[s]), int'(age[s]),
                                                        int'(best_prio), int'(best_age)))) begin
                found     = 1'b1;
                win       = SLOT_W'(s);
                best_age  = age[s];
                best_prio = prio[s];
            end
        end
    end
endmodule

// File: rtl/wia_issue_arb.sv
module wia_issue_arb #(
    parameter int NUM_GROUPS      = 4,
    parameter int WAVES_PER_GROUP = 10,
    parameter int AGE_W           = 8,
    parameter int PRIO_W          = 2,
    localparam int NW     = NUM_GROUPS * WAVES_PER_GROUP,
    localparam int NCAT   = wia_pkg::NUM_CAT,
    localparam int WID_W  = (NW > 1) ? $clog2(NW) : 1,
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int SLOT_W = (WAVES_PER_GROUP > 1) ? $clog2(WAVES_PER_GROUP) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NW-1:0]         wave_ready,
    input  logic [NW*NCAT-1:0]    wave_cat_mask,
    input  logic [NW*AGE_W-1:0]   wave_age,
    input  logic [NW*PRIO_W-1:0]  wave_prio,
    output logic [NCAT-1:0]       grant_valid,
    output logic [NCAT*WID_W-1:0] grant_wave,
    output logic [GRP_W-1:0]      grant_group
);
    import wia_pkg::*;

    localparam int SLOTS = WAVES_PER_GROUP;

    logic [GRP_W-1:0]  grp;
    logic [SLOTS-1:0]  elig      [NCAT];
    logic [AGE_W-1:0]  slot_age  [SLOTS];
    logic [PRIO_W-1:0] slot_prio [SLOTS];

    logic [SLOTS-1:0]  taken   [NCAT+1];
    logic [CNT_W-1:0]  ext_cnt [NCAT+1];
    logic [NCAT-1:0]   pick_found;
    logic [SLOT_W-1:0] pick_win [NCAT];

    wia_group_ctr #(.NUM_GROUPS(NUM_GROUPS)) u_grp (
        .clk (clk),
        .rst (rst),
        .grp (grp)
    );

    wia_slot_view #(
        .NUM_GROUPS(NUM_GROUPS), .SLOTS(SLOTS), .AGE_W(AGE_W), .PRIO_W(PRIO_W)
    ) u_view (
        .grp           (grp),
        .wave_ready    (wave_ready),
        .wave_cat_mask (wave_cat_mask),
        .wave_age      (wave_age),
        .wave_prio     (wave_prio),
        .elig          (elig),
        .slot_age      (slot_age),
        .slot_prio     (slot_prio)
    );

    assign taken[0]   = '0;
    assign ext_cnt[0] = '0;

    // Category chain: each stage sees only waves not taken by lower categories.
    for (genvar c = 0; c < NCAT; c++) begin : g_cat
        logic             cap_ok;
        logic [SLOTS-1:0] cand;

        if (c < NUM_EXT) begin : g_ext
            assign cap_ok         = (int'(ext_cnt[c]) < MAX_EXT_ISSUE);
            assign ext_cnt[c+1]   = ext_cnt[c] + CNT_W'(pick_found[c]);
        end else begin : g_int
            assign cap_ok         = 1'b1;
            assign ext_cnt[c+1]   = ext_cnt[c];
        end

        assign cand = elig[c] & ~taken[c] & {SLOTS{cap_ok}};

        wia_cat_pick #(.SLOTS(SLOTS), .AGE_W(AGE_W), .PRIO_W(PRIO_W)) u_pick (
            .cand  (cand),
            .age   (slot_age),
            .prio  (slot_prio),
            .found (pick_found[c]),
            .win   (pick_win[c])
        );

        assign taken[c+1] = taken[c] | (pick_found[c] ? (SLOTS'(1) << pick_win[c]) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= '0;
            grant_wave  <= '0;
            grant_group <= '0;
        end else begin
            grant_group <= grp;
            for (int c = 0; c < NCAT; c++) begin
                grant_valid[c] <= pick_found[c];
                grant_wave[c*WID_W +: WID_W] <= pick_found[c]
                    ? WID_W'(int'(grp) * SLOTS + int'(pick_win[c])) : '0;
            end
        end
    end

    AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_valid[NUM_EXT-1:0]) <= MAX_EXT_ISSUE) // R6
        else $error("external issue limit exceeded");

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (grant_valid == '0 && grant_group == '0)) // R8
        else $error("outputs active after reset");

    for (genvar a = 0; a < NCAT; a++) begin : g_chk
        AST_GROUP_MEMBER: assert property (@(posedge clk) disable iff (rst)
            grant_valid[a] |-> (int'(grant_wave[a*WID_W +: WID_W]) / SLOTS == int'(grant_group))) // R2
            else $error("grant outside served group");

        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !grant_valid[a] |-> (grant_wave[a*WID_W +: WID_W] == '0)) // R7
            else $error("idle category carries a wave id");

        for (genvar b = a + 1; b < NCAT; b++) begin : g_pair
            AST_ONE_PER_WAVE: assert property (@(posedge clk) disable iff (rst)
                (grant_valid[a] && grant_valid[b]) |->
                    (grant_wave[a*WID_W +: WID_W] != grant_wave[b*WID_W +: WID_W])) // R5
                else $error("wave granted twice");
        end
    end
endmodule

// File: tb/wia_issue_arb_test.sv
module wia_issue_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NG    = 4;
    localparam int WPG   = 10;
    localparam int AGE_W = 8;
    localparam int PRIO_W = 2;
    localparam int NW    = NG * WPG;
    localparam int NCAT  = 7;
    localparam int WID_W = $clog2(NW);
    localparam int GRP_W = $clog2(NG);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NW-1:0]         wave_ready;
    logic [NW*NCAT-1:0]    wave_cat_mask;
    logic [NW*AGE_W-1:0]   wave_age;
    logic [NW*PRIO_W-1:0]  wave_prio;
    logic [NCAT-1:0]       grant_valid;
    logic [NCAT*WID_W-1:0] grant_wave;
    logic [GRP_W-1:0]      grant_group;

    bit              rdy [NW];
    bit [NCAT-1:0]   msk [NW];
    int              age [NW];
    int              pri [NW];

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            wave_ready[w] = rdy[w];
            wave_cat_mask[w*NCAT +: NCAT] = msk[w];
            wave_age[w*AGE_W +: AGE_W] = AGE_W'(age[w]);
            wave_prio[w*PRIO_W +: PRIO_W] = PRIO_W'(pri[w]);
        end
    end

    wia_issue_arb #(.NUM_GROUPS(NG), .WAVES_PER_GROUP(WPG), .AGE_W(AGE_W), .PRIO_W(PRIO_W)) uut (
        .clk(clk), .rst(rst), .wave_ready(wave_ready), .wave_cat_mask(wave_cat_mask),
        .wave_age(wave_age), .wave_prio(wave_prio), .grant_valid(grant_valid),
        .grant_wave(grant_wave), .grant_group(grant_group)
    );

    int checks = 0;
    int errors = 0;
    int model_grp = 0;
    bit exp_v [NCAT];
    int exp_w [NCAT];
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected grants from the requirements: order, cap, priority/age/index.
    task automatic model(input int g);
        bit tk [WPG];
        int cnt = 0;
        for (int s = 0; s < WPG; s++) tk[s] = 0;
        for (int c = 0; c < NCAT; c++) begin
            int best = -1;
            int bp = 0;
            int ba = 0;
            if (c >= 6 || cnt < 5) begin
                for (int s = 0; s < WPG; s++) begin
                    int w = g * WPG + s;
                    if (rdy[w] && msk[w][c] && !tk[s] &&
                        (best < 0 || pri[w] > bp || (pri[w] == bp && age[w] > ba))) begin
                        best = s; bp = pri[w]; ba = age[w];
                    end
                end
            end
            exp_v[c] = (best >= 0);
            exp_w[c] = (best >= 0) ? g * WPG + best : 0;
            if (best >= 0) begin
                tk[best] = 1;
                if (c < 6) cnt++;
            end
        end
    endtask

    task automatic step(input string req);
        model(model_grp);
        @(posedge clk);
        #1;
        check(int'(grant_group) == model_grp, "R1", "group", int'(grant_group), model_grp);
        for (int c = 0; c < NCAT; c++) begin
            check(grant_valid[c] == exp_v[c], req, $sformatf("valid cat%0d", c),
                  int'(grant_valid[c]), int'(exp_v[c]));
            check(int'(grant_wave[c*WID_W +: WID_W]) == exp_w[c], req, $sformatf("wave cat%0d", c),
                  int'(grant_wave[c*WID_W +: WID_W]), exp_w[c]);
        end
        model_grp = (model_grp + 1) % NG;
    endtask

    task automatic clear_all();
        for (int w = 0; w < NW; w++) begin
            rdy[w] = 0; msk[w] = '0; age[w] = 0; pri[w] = 0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd1234));
        clear_all();
        repeat (3) @(posedge clk);
        #1;
        check(grant_valid == '0, "R8", "reset valid", int'(grant_valid), 0);
        check(grant_group == '0, "R8", "reset group", int'(grant_group), 0);
        check(grant_wave == '0, "R8", "reset wave", 0, 0);
        rst = 1'b0;
        model_grp = 0;

        // R7: nothing ready at all
        step("R7");

        // R6: six waves each on one external category, one internal
        base = model_grp * WPG;
        for (int s = 0; s < 7; s++) begin
            rdy[base+s] = 1; msk[base+s] = NCAT'(1) << s; pri[base+s] = 1; age[base+s] = 3;
        end
        step("R6");
        check(grant_valid[5] == 1'b0, "R6", "export blocked by cap", int'(grant_valid[5]), 0);
        check(grant_valid[6] == 1'b1, "R6", "internal still grants", int'(grant_valid[6]), 1);
        clear_all();

        // R5: one strong wave eligible everywhere
        base = model_grp * WPG;
        rdy[base+4] = 1; msk[base+4] = 7'h7F; pri[base+4] = 3; age[base+4] = 1;
        rdy[base+2] = 1; msk[base+2] = 7'h03; pri[base+2] = 1; age[base+2] = 1;
        step("R5");
        check(int'(grant_wave[0 +: WID_W]) == base + 4, "R5", "cat0 to strong wave",
              int'(grant_wave[0 +: WID_W]), base + 4);
        check(int'(grant_wave[WID_W +: WID_W]) == base + 2, "R5", "cat1 to other wave",
              int'(grant_wave[WID_W +: WID_W]), base + 2);
        clear_all();

        // R4: equal priority, older wins; full tie goes to lower index
        base = model_grp * WPG;
        rdy[base+1] = 1; msk[base+1] = 7'h01; pri[base+1] = 2; age[base+1] = 5;
        rdy[base+7] = 1; msk[base+7] = 7'h01; pri[base+7] = 2; age[base+7] = 9;
        rdy[base+3] = 1; msk[base+3] = 7'h04; pri[base+3] = 1; age[base+3] = 6;
        rdy[base+8] = 1; msk[base+8] = 7'h04; pri[base+8] = 1; age[base+8] = 6;
        step("R4");
        check(int'(grant_wave[0 +: WID_W]) == base + 7, "R4", "older wins",
              int'(grant_wave[0 +: WID_W]), base + 7);
        check(int'(grant_wave[2*WID_W +: WID_W]) == base + 3, "R4", "lower index wins tie",
              int'(grant_wave[2*WID_W +: WID_W]), base + 3);
        clear_all();

        // R2: ready waves only outside the served group
        for (int w = 0; w < NW; w++) begin
            if (w / WPG != model_grp) begin
                rdy[w] = 1; msk[w] = 7'h7F; pri[w] = 3;
            end
        end
        step("R2");
        check(grant_valid == '0, "R2", "no grant from other groups", int'(grant_valid), 0);
        clear_all();

        // R3: masks present but not ready; then ready without mask
        base = model_grp * WPG;
        for (int s = 0; s < WPG; s++) msk[base+s] = 7'h7F;
        step("R3");
        check(grant_valid == '0, "R3", "not ready ignored", int'(grant_valid), 0);
        clear_all();
        base = model_grp * WPG;
        for (int s = 0; s < WPG; s++) rdy[base+s] = 1;
        step("R3");
        clear_all();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < NW; w++) begin
                rdy[w] = ($urandom % 2) == 0;
                for (int c = 0; c < NCAT; c++) msk[w][c] = ($urandom % 4) == 0;
                age[w] = $urandom % 8;
                pri[w] = $urandom % 4;
            end
            step("R4");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule